// File: doc/BRIEF.md
# Bulk Endpoint DMA Termination Controller

This block sits between a system DMA engine and one bulk endpoint buffer of a USB device controller. It raises a request towards the DMA engine while a transfer is armed. It qualifies each acknowledge strobe as one 16-bit word moved, and it counts down the bytes that remain. It also decides when the transfer is over. Four events can end a transfer: an end-of-transfer pulse from outside, the byte count running out, a short or empty packet arriving on an OUT endpoint, and software dropping the DMA enable bit.

The effect on the endpoint depends on what ended the transfer and on the direction. An outside end-of-transfer during an OUT transfer discards the data held in the buffer that is active at that moment. When the endpoint is double-buffered, the other half keeps its data. On an IN endpoint, an outside end-of-transfer or a count that runs out commits the partly filled buffer, so that it goes out at the next IN token. A sticky one-hot status word records the cause until software reads it. After any termination the block stays idle until the enable bit rises again.

Top module: `bulk_dma_term`

## Requirements
- R1: After reset, dreq, stop, send_now, every flush_out bit, status, byte_left and act_buf are all zero.
- R2: A transfer starts when dma_en goes from 0 to 1: dreq is high after the next clock edge. Once a transfer has ended, keeping dma_en high does not start another one.
- R3: In normal mode (dack_only=0), a word is accepted only when dack is high together with rd_strb for an OUT transfer (dir_in=0) or wr_strb for an IN transfer (dir_in=1). In dack-only mode, dack alone accepts a word and rd_strb and wr_strb have no effect. Strobes are ignored while dreq is low.
- R4: cnt_load writes cnt_val into byte_left. Each accepted word takes 2 from byte_left, or takes it to 0 when fewer than 2 bytes remain. byte_left never wraps below 0.
- R5: With cnt_en=1, an accepted word that leaves byte_left at 0 ends the transfer. With cnt_en=0, the transfer goes on after the count has run out.
- R6: During an OUT transfer, ext_eot ends the transfer and pulses for one cycle only the flush_out bit of the active buffer (bit index = act_buf).
- R7: During an IN transfer, ext_eot ends the transfer and pulses send_now for one cycle. No flush_out bit rises.
- R8: During an IN transfer with cnt_en=1, a count that runs out pulses send_now for one cycle.
- R9: short_pkt ends an OUT transfer only when short_en=1. It has no effect when short_en=0 or when dir_in=1.
- R10: Clearing dma_en during a transfer ends it. Clearing dma_en while idle records no cause.
- R11: dreq is low after the clock edge that follows the cycle in which a condition was detected, and stop is high for exactly that one cycle.
- R12: status is one-hot: bit0 = external end-of-transfer, bit1 = count reached zero, bit2 = short packet, bit3 = enable cleared. It holds its value until stat_rd clears it. If a new cause arrives in the same cycle as stat_rd, status shows the new cause.
- R13: When several conditions occur in the same cycle, only the highest one is recorded. The order, highest first, is: external end-of-transfer, count zero, short packet, enable cleared.
- R14: With double buffering, each buf_swap pulse toggles act_buf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en | input | 1 | DMA enable bit; a rising edge arms a transfer |
| cnt_en | input | 1 | Byte count running out ends the transfer |
| short_en | input | 1 | Short or empty OUT packet ends the transfer |
| dir_in | input | 1 | 1 = IN (memory to endpoint), 0 = OUT |
| dack_only | input | 1 | Acknowledge alone acts as the data strobe |
| cnt_load | input | 1 | Write cnt_val into the byte counter |
| cnt_val | input | CW (16) | Byte count to load |
| dack | input | 1 | DMA acknowledge |
| rd_strb | input | 1 | Read strobe (OUT direction) |
| wr_strb | input | 1 | Write strobe (IN direction) |
| ext_eot | input | 1 | External end-of-transfer pulse |
| short_pkt | input | 1 | Short or empty packet received on the endpoint |
| buf_swap | input | 1 | Active half of the double buffer changes |
| stat_rd | input | 1 | Status read; clears status |
| dreq | output | 1 | DMA request |
| stop | output | 1 | One-cycle pulse when a transfer ends |
| flush_out | output | NBUF (2) | Discard pulse, one bit per buffer half |
| send_now | output | 1 | Commit the partly filled IN buffer |
| status | output | 4 | Sticky one-hot cause of the last termination |
| byte_left | output | CW (16) | Bytes remaining |
| act_buf | output | 1 | Index of the active buffer half |

## Verification
Every result is registered, so each output reacts exactly one clock edge after the input cycle that caused it. This holds for dreq, stop, flush_out, send_now, status, byte_left and act_buf. The driver changes inputs on the falling edge and files each expected value as due at the next rising edge. The monitor samples shortly after that rising edge and compares only the entries whose due cycle has come. One-cycle pulses such as stop, flush_out and send_now are checked both in the cycle they are due and in the cycle after, where they must be low again.

// File: rtl/bdt_pkg.sv
package bdt_pkg;

    typedef enum logic [1:0] {
        CAUSE_EOT   = 2'd0,
        CAUSE_CNT   = 2'd1,
        CAUSE_SHORT = 2'd2,
        CAUSE_OFF   = 2'd3
    } cause_e;

    localparam int CAUSE_N = 4;

    typedef struct packed {
        logic               run;
        logic               en_seen;
        logic               stop;
        logic               send;
        logic [CAUSE_N-1:0] status;
    } ctl_s;

endpackage

// File: rtl/bdt_strobe.sv
module bdt_strobe (
    input  logic dack_only,
    input  logic dir_in,
    input  logic dack,
    input  logic rd_strb,
    input  logic wr_strb,
    output logic strb
);
    logic dir_strb;

    always_comb begin
        dir_strb = dir_in ? wr_strb : rd_strb;
        strb     = dack_only ? dack : (dack & dir_strb);
    end
endmodule

// File: rtl/bdt_bytecnt.sv
module bdt_bytecnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic [CW-1:0] left,
    output logic          last
);
    localparam logic [CW-1:0] WORD_BYTES = CW'(2);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (load) begin
            left_d = load_val;
        end else if (step) begin
            if (left_q >= WORD_BYTES) left_d = left_q - WORD_BYTES;
            else                      left_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign left = left_q;
    assign last = (left_q <= WORD_BYTES);

    // R4: a full word takes two bytes
    a_r4_dec_two: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && left_q >= WORD_BYTES) |=> (left_q == $past(left_q) - WORD_BYTES));

    // R4: the count floors at zero
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && left_q < WORD_BYTES) |=> (left_q == '0));
endmodule

// File: rtl/bdt_bufsel.sv
module bdt_bufsel #(
    parameter bit DBL_BUF = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic swap,
    output logic act
);
    generate
        if (DBL_BUF) begin : g_dbl
            logic act_d, act_q;

            always_comb begin
                act_d = act_q;
                if (swap) act_d = ~act_q;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) act_q <= 1'b0;
                else        act_q <= act_d;
            end

            assign act = act_q;

            // R14: each swap pulse moves to the other half
            a_r14_toggle: assert property (@(posedge clk) disable iff (!rst_n)
                swap |=> (act_q != $past(act_q)));
        end else begin : g_single
            assign act = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/bulk_dma_term.sv
module bulk_dma_term #(
    parameter int CW      = 16,
    parameter bit DBL_BUF = 1'b1,
    localparam int NBUF   = DBL_BUF ? 2 : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dma_en,
    input  logic            cnt_en,
    input  logic            short_en,
    input  logic            dir_in,
    input  logic            dack_only,
    input  logic            cnt_load,
    input  logic [CW-1:0]   cnt_val,
    input  logic            dack,
    input  logic            rd_strb,
    input  logic            wr_strb,
    input  logic            ext_eot,
    input  logic            short_pkt,
    input  logic            buf_swap,
    input  logic            stat_rd,
    output logic            dreq,
    output logic            stop,
    output logic [NBUF-1:0] flush_out,
    output logic            send_now,
    output logic [3:0]      status,
    output logic [CW-1:0]   byte_left,
    output logic            act_buf
);
    import bdt_pkg::*;

    ctl_s            ctl_d, ctl_q;
    logic [NBUF-1:0] flush_d, flush_q;
    logic            strb, word_ok, cnt_last;
    logic            c_eot, c_cnt, c_short, c_off, term;
    cause_e          cause;

    bdt_strobe u_strobe (
        .dack_only (dack_only),
        .dir_in    (dir_in),
        .dack      (dack),
        .rd_strb   (rd_strb),
        .wr_strb   (wr_strb),
        .strb      (strb)
    );

    bdt_bytecnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .step     (word_ok),
        .left     (byte_left),
        .last     (cnt_last)
    );

    bdt_bufsel #(.DBL_BUF(DBL_BUF)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .swap  (buf_swap),
        .act   (act_buf)
    );

    always_comb begin
        word_ok = ctl_q.run & strb;
        c_eot   = ctl_q.run & ext_eot;
        c_cnt   = word_ok & cnt_en & cnt_last;
        c_short = ctl_q.run & short_en & ~dir_in & short_pkt;
        c_off   = ctl_q.run & ~dma_en;
        term    = c_eot | c_cnt | c_short | c_off;

        if (c_eot)        cause = CAUSE_EOT;
        else if (c_cnt)   cause = CAUSE_CNT;
        else if (c_short) cause = CAUSE_SHORT;
        else              cause = CAUSE_OFF;

        ctl_d         = ctl_q;
        ctl_d.en_seen = dma_en;
        ctl_d.stop    = 1'b0;
        ctl_d.send    = 1'b0;
        flush_d       = '0;

        if (stat_rd) ctl_d.status = '0;

        if (term) begin
            ctl_d.run    = 1'b0;
            ctl_d.stop   = 1'b1;
            ctl_d.status = 4'b0001 << cause;
            if (cause == CAUSE_EOT && !dir_in) flush_d[act_buf] = 1'b1;
            if (dir_in && (cause == CAUSE_EOT || cause == CAUSE_CNT)) ctl_d.send = 1'b1;
        end else if (!ctl_q.run && dma_en && !ctl_q.en_seen) begin
            ctl_d.run = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            flush_q <= '0;
        end else begin
            ctl_q   <= ctl_d;
            flush_q <= flush_d;
        end
    end

    assign dreq      = ctl_q.run;
    assign stop      = ctl_q.stop;
    assign send_now  = ctl_q.send;
    assign status    = ctl_q.status;
    assign flush_out = flush_q;

    // R11: request withdrawn right after detection
    a_r11_dreq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> !dreq);

    // R11: stop lasts one cycle
    a_r11_stop_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !stop);

    // R6: discard only after outside end-of-transfer on OUT
    a_r6_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_out) |-> ($past(ext_eot) && !$past(dir_in)));

    // R6: never both halves at once
    a_r6_one_half: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_out));

    // R7: commit and discard never together
    a_r7_no_mix: assert property (@(posedge clk) disable iff (!rst_n)
        !(send_now && (|flush_out)));

    // R12: one cause at a time
    a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status));

    // R2: no request without a preceding start or running state
    a_r2_start_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> ($past(dma_en) && !$past(dreq)));
endmodule

// File: tb/bulk_dma_term_bench.sv
`timescale 1ns/1ps
module bulk_dma_term_bench;
    localparam int CW = 16;

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dma_en = 0, cnt_en = 0, short_en = 0, dir_in = 0, dack_only = 0;
    logic          cnt_load = 0, dack = 0, rd_strb = 0, wr_strb = 0;
    logic          ext_eot = 0, short_pkt = 0, buf_swap = 0, stat_rd = 0;
    logic [CW-1:0] cnt_val = '0;
    logic          dreq, stop, send_now, act_buf;
    logic [1:0]    flush_out;
    logic [3:0]    status;
    logic [CW-1:0] byte_left;

    int    cyc = 0;
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    item_t sb[$];

    always #2.5 clk = ~clk;

    bulk_dma_term u_bulk_dma_term (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .cnt_en(cnt_en),
        .short_en(short_en), .dir_in(dir_in), .dack_only(dack_only),
        .cnt_load(cnt_load), .cnt_val(cnt_val), .dack(dack),
        .rd_strb(rd_strb), .wr_strb(wr_strb), .ext_eot(ext_eot),
        .short_pkt(short_pkt), .buf_swap(buf_swap), .stat_rd(stat_rd),
        .dreq(dreq), .stop(stop), .flush_out(flush_out), .send_now(send_now),
        .status(status), .byte_left(byte_left), .act_buf(act_buf)
    );

    function automatic logic [31:0] observe(int sel);
        case (sel)
            0:       return {31'd0, dreq};
            1:       return {31'd0, stop};
            2:       return {30'd0, flush_out};
            3:       return {31'd0, send_now};
            4:       return {28'd0, status};
            5:       return {16'd0, byte_left};
            default: return {31'd0, act_buf};
        endcase
    endfunction

    function automatic string sel_name(int sel);
        case (sel)
            0: return "dreq";      1: return "stop";
            2: return "flush_out"; 3: return "send_now";
            4: return "status";    5: return "byte_left";
            default: return "act_buf";
        endcase
    endfunction

    // monitor: samples just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [31:0] got;
                it  = sb.pop_front();
                got = observe(it.sel);
                checks++;
                if (got !== it.exp) begin
                    failures++;
                    $display("FAIL %s %s: got %0h expected %0h (cycle %0d)",
                             it.req, sel_name(it.sel), got, it.exp, cyc);
                end
            end
        end
    end

    task automatic expect_at(int sel, logic [31:0] val, string req);
        item_t it;
        it.due = cyc + 1;
        it.sel = sel;
        it.exp = val;
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk);
        cnt_load = 0; dack = 0; rd_strb = 0; wr_strb = 0;
        ext_eot = 0; short_pkt = 0; buf_swap = 0; stat_rd = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        tick();
        expect_at(0, 0, "R1"); expect_at(1, 0, "R1"); expect_at(2, 0, "R1");
        expect_at(3, 0, "R1"); expect_at(4, 0, "R1"); expect_at(5, 0, "R1");
        expect_at(6, 0, "R1");

        // OUT, normal mode, count termination enabled
        tick(); dir_in = 0; dack_only = 0; cnt_en = 1; short_en = 0;
        cnt_load = 1; cnt_val = 16'd5; expect_at(5, 5, "R4");
        tick(); dma_en = 1; expect_at(0, 1, "R2");
        tick(); dack = 1; expect_at(5, 5, "R3");
        tick(); dack = 1; rd_strb = 1; expect_at(5, 3, "R4");
        tick(); dack = 1; wr_strb = 1; expect_at(5, 3, "R3");
        tick(); dack = 1; rd_strb = 1; expect_at(5, 1, "R4");
        tick(); dack = 1; rd_strb = 1;
        expect_at(5, 0, "R4"); expect_at(0, 0, "R11"); expect_at(1, 1, "R11");
        expect_at(4, 4'b0010, "R5"); expect_at(3, 0, "R5"); expect_at(2, 0, "R5");
        tick(); expect_at(1, 0, "R11"); expect_at(0, 0, "R2"); expect_at(4, 4'b0010, "R12");
        tick(); stat_rd = 1; expect_at(4, 0, "R12");
        tick(); cnt_load = 1; cnt_val = 16'd4; expect_at(5, 4, "R4");
        tick(); dack = 1; rd_strb = 1; expect_at(5, 4, "R3");
        tick(); dma_en = 0; expect_at(0, 0, "R10"); expect_at(4, 0, "R10");
        tick(); dma_en = 1; expect_at(0, 1, "R2");

        // double buffer and outside end-of-transfer on OUT
        tick(); buf_swap = 1; expect_at(6, 1, "R14");
        tick(); ext_eot = 1;
        expect_at(2, 2'b10, "R6"); expect_at(0, 0, "R6");
        expect_at(4, 4'b0001, "R6"); expect_at(3, 0, "R6");
        tick(); expect_at(2, 0, "R6");

        // count runs out with termination disabled
        tick(); cnt_en = 0; dma_en = 0;
        tick(); dma_en = 1; expect_at(0, 1, "R2");
        tick(); dack = 1; rd_strb = 1; expect_at(5, 2, "R4");
        tick(); dack = 1; rd_strb = 1; expect_at(5, 0, "R5"); expect_at(0, 1, "R5");
        tick(); dack = 1; rd_strb = 1; expect_at(5, 0, "R4"); expect_at(0, 1, "R5");

        // short packet
        tick(); short_pkt = 1; expect_at(0, 1, "R9"); expect_at(4, 4'b0001, "R9");
        tick(); short_en = 1; short_pkt = 1;
        expect_at(0, 0, "R9"); expect_at(4, 4'b0100, "R9"); expect_at(2, 0, "R9");

        // enable cleared
        tick(); dma_en = 0; short_en = 0;
        tick(); dma_en = 1; expect_at(0, 1, "R2");
        tick(); dma_en = 0;
        expect_at(0, 0, "R10"); expect_at(4, 4'b1000, "R10"); expect_at(1, 1, "R10");

        // IN, dack-only mode
        tick(); dir_in = 1; dack_only = 1; cnt_en = 1;
        cnt_load = 1; cnt_val = 16'd3; expect_at(5, 3, "R4");
        tick(); dma_en = 1; expect_at(0, 1, "R2");
        tick(); rd_strb = 1; wr_strb = 1; expect_at(5, 3, "R3");
        tick(); dack = 1; expect_at(5, 1, "R3");
        tick(); dack = 1;
        expect_at(3, 1, "R8"); expect_at(4, 4'b0010, "R8");
        expect_at(2, 0, "R8"); expect_at(0, 0, "R8");
        tick(); expect_at(3, 0, "R8");
        tick(); dma_en = 0;
        tick(); dma_en = 1; cnt_load = 1; cnt_val = 16'd10;
        expect_at(0, 1, "R2"); expect_at(5, 10, "R4");
        tick(); ext_eot = 1;
        expect_at(3, 1, "R7"); expect_at(2, 0, "R7"); expect_at(4, 4'b0001, "R7");
        tick(); expect_at(3, 0, "R7");

        // priority: all three of eot, count and short in one cycle
        tick(); dir_in = 0; dack_only = 0; cnt_en = 1; short_en = 1; dma_en = 0;
        cnt_load = 1; cnt_val = 16'd2;
        tick(); dma_en = 1; expect_at(0, 1, "R2");
        tick(); dack = 1; rd_strb = 1; ext_eot = 1; short_pkt = 1;
        expect_at(4, 4'b0001, "R13"); expect_at(2, 2'b10, "R13");
        tick(); dma_en = 0;
        tick(); dma_en = 1; cnt_load = 1; cnt_val = 16'd2; expect_at(0, 1, "R2");
        tick(); dack = 1; rd_strb = 1; short_pkt = 1; stat_rd = 1;
        expect_at(4, 4'b0010, "R13"); expect_at(0, 0, "R13");
        tick(); dma_en = 0; expect_at(4, 4'b0010, "R12");
        tick(); dma_en = 1; expect_at(0, 1, "R2");
        tick(); dma_en = 0; short_pkt = 1;
        expect_at(4, 4'b0100, "R13"); expect_at(0, 0, "R13");
        tick(); buf_swap = 1; expect_at(6, 0, "R14");

        tick();
        tick();
        tick();
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
        end
        finish_run();
    end
endmodule